// File: doc/BRIEF.md
# Folded Rate-1/2 Convolutional LDPC Encoder

This block is a systematic encoder for a rate-1/2 low-density parity-check convolutional code. The code's parity-check equation changes with the serial bit time and repeats every three bits. The encoder is folded by three, which is one full period, so it takes a 3-bit information word in each clock cycle and produces a 6-bit code word: the three information bits and the three parity bits that go with them. Because the folding factor equals the period, every lane always sees the same tap pattern. The XOR trees are therefore wired at fixed points, and no phase-selection multiplexer is needed.

Every serial delay line is split into three interleaved lines, one per lane, and each line is a third as long. The lanes are lane 0 (the oldest serial position), lane 1 and lane 2. Each lane has its own parity XOR tree. For the serial bit time s, the parity is v(s) = u(s) ^ u(s-5) ^ u(s-11) ^ v(s-7) ^ v(s-14). This is what each of the three phase constraints gives when it is solved for its lowest-degree parity term. Bits before the last reset or flush count as zero.

Both edges use a valid/ready handshake. The output register is driven by a two-state controller:
- ST_EMPTY: no word is held. It moves to ST_FULL on an accepted input.
- ST_FULL: a word is held. It stays in ST_FULL when the held word is consumed and a new input is accepted in the same cycle. It returns to ST_EMPTY when the word is consumed with no new input.
- From either state, a flush or a reset goes to ST_EMPTY.

Top module: `ldpcc_fold_enc`

## Requirements
- R1: After a synchronous reset, out_valid is 0, in_ready is 1 and all delay-line state is zero, so a stream of all-zero information words encodes to all-zero code words.
- R2: For serial time s = 3k+j, where k is the word index since the last reset or flush and j is the lane 0..2 (in_info[j]), the parity is v(s) = u(s) ^ u(s-5) ^ u(s-11) ^ v(s-7) ^ v(s-14). Terms with negative time count as zero.
- R3: out_word = {v2,v1,v0,u2,u1,u0}. Bits [2:0] are the accepted in_info unchanged, and bit 3+j is the parity of lane j.
- R4: An input is accepted at a clock edge where in_valid and in_ready are both 1. out_valid is 1 after that edge, which is one cycle of latency.
- R5: While out_valid is 1 and out_ready is 0 (with no flush), out_word and out_valid stay unchanged and in_ready is 0.
- R6: While out_ready is 1 and flush is 0, in_ready is 1, so one word is accepted every cycle.
- R7: A flush cycle drops any held output word (out_valid is 0 after it) and clears all delay-line state. Encoding then restarts exactly as after reset.
- R8: Cycles with no accepted input (in_valid low, or in_ready low) do not advance the delay lines. The code sequence depends only on the accepted words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of delay lines and the held output |
| in_valid | input | 1 | Information word present |
| in_ready | output | 1 | Encoder can take a word this cycle |
| in_info | input | 3 | Information bits, bit j is lane j (bit 0 is oldest) |
| out_valid | output | 1 | Code word present |
| out_ready | input | 1 | Consumer takes the code word this cycle |
| out_word | output | 6 | Code word {v2,v1,v0,u2,u1,u0} |

## Verification
- **Zero stream:** shows that reset leaves no stray state behind.
- **Single-one impulse after a flush:** walks one bit through every delay line, so a missing or misplaced tap, or a lane that reads the wrong interleaved line, shows up as a wrong parity position.
- **Long random streams:** run with idle gaps and with random consumer stalls. They tell correct holding of state apart from advancing the delay lines on cycles with no transfer.
- **Back-to-back burst and flush of a stalled word:** the burst, with the consumer always ready, shows full throughput. The flush of a word held under stall shows that the pending word is discarded and that encoding restarts from a clean history.

// File: rtl/ldpcc_pkg.sv
package ldpcc_pkg;
    localparam int FOLD   = 3;
    localparam int N_UTAP = 3;
    localparam int N_VTAP = 2;
    // serial distances of the information and parity taps
    localparam int U_TAPS [N_UTAP] = '{0, 5, 11};
    localparam int V_TAPS [N_VTAP] = '{7, 14};
    // history depth: oldest serial bit any lane reaches
    localparam int HIST   = 14;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } enc_state_t;
endpackage

// File: rtl/ldpcc_fold_delay.sv
// Folded delay line: hist[i] holds the serial bit i+1 positions older than
// lane 0 of the current word. Each shift moves FOLD bits in at once, so the
// storage forms FOLD interleaved lines of length DEPTH/FOLD.
module ldpcc_fold_delay #(
    parameter int FOLD  = 3,
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic [FOLD-1:0]  din,
    output logic [DEPTH-1:0] hist
);
    logic [DEPTH-1:0] nxt;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i < FOLD) begin : g_in
            assign nxt[i] = din[FOLD-1-i];
        end else begin : g_mv
            assign nxt[i] = hist[i-FOLD];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= '0;
        end else if (shift) begin
            hist <= nxt;
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hist == '0)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clr) |=> $stable(hist)); // R8
endmodule

// File: rtl/ldpcc_parity_lane.sv
// One lane of the replicated parity XOR tree. The tap positions are fixed
// because the fold equals the code period.
module ldpcc_parity_lane
    import ldpcc_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [FOLD-1:0] u_now,
    input  logic [HIST-1:0] u_hist,
    input  logic [HIST-1:0] v_hist,
    output logic            v_out
);
    logic [N_UTAP-1:0] ub;
    logic [N_VTAP-1:0] vb;

    for (genvar t = 0; t < N_UTAP; t++) begin : g_ut
        if (U_TAPS[t] <= LANE) begin : g_cur
            assign ub[t] = u_now[LANE-U_TAPS[t]];
        end else begin : g_old
            assign ub[t] = u_hist[U_TAPS[t]-LANE-1];
        end
    end

    // parity taps always reach into earlier words (min distance > FOLD-1)
    for (genvar t = 0; t < N_VTAP; t++) begin : g_vt
        assign vb[t] = v_hist[V_TAPS[t]-LANE-1];
    end

    assign v_out = (^ub) ^ (^vb);
endmodule

// File: rtl/ldpcc_ctrl.sv
module ldpcc_ctrl
    import ldpcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic accept,
    output logic out_valid
);
    enc_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = ST_EMPTY;
        end else begin
            unique case (state)
                ST_EMPTY: if (in_valid) state_nxt = ST_FULL;
                ST_FULL:  if (out_ready && !in_valid) state_nxt = ST_EMPTY;
                default:  state_nxt = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        out_valid = (state == ST_FULL);
        in_ready  = !flush && ((state == ST_EMPTY) || out_ready);
        accept    = in_valid && in_ready;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid); // R4

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R5

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        (out_ready && !flush) |-> in_ready); // R6

    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid); // R7
endmodule

// File: rtl/ldpcc_fold_enc.sv
module ldpcc_fold_enc
    import ldpcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [FOLD-1:0]     in_info,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*FOLD-1:0]   out_word
);
    logic            accept;
    logic [HIST-1:0] u_hist;
    logic [HIST-1:0] v_hist;
    logic [FOLD-1:0] v_now;

    ldpcc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .accept    (accept),
        .out_valid (out_valid)
    );

    ldpcc_fold_delay #(.FOLD(FOLD), .DEPTH(HIST)) u_dly_info (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush),
        .shift (accept),
        .din   (in_info),
        .hist  (u_hist)
    );

    ldpcc_fold_delay #(.FOLD(FOLD), .DEPTH(HIST)) u_dly_par (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush),
        .shift (accept),
        .din   (v_now),
        .hist  (v_hist)
    );

    for (genvar j = 0; j < FOLD; j++) begin : g_lane
        ldpcc_parity_lane #(.LANE(j)) u_lane (
            .u_now  (in_info),
            .u_hist (u_hist),
            .v_hist (v_hist),
            .v_out  (v_now[j])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            out_word <= '0;
        end else if (accept) begin
            out_word <= {v_now, in_info};
        end
    end

    AST_INFO_PASS: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_word[FOLD-1:0] == $past(in_info))); // R3

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_word))); // R5
endmodule

// File: tb/ldpcc_fold_enc_tb.sv
module ldpcc_fold_enc_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_info = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [5:0] out_word;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;      // 0: always ready, 1: pseudo-random, 2: never
    int stall_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic done = 1'b0;

    logic [5:0] exp_q [$];
    string      tag_q [$];

    bit ref_u [0:4095];
    bit ref_v [0:4095];
    int ref_cnt = 0;

    always #4 clk = ~clk;

    ldpcc_fold_enc u_dut (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_info   (in_info),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word)
    );

    function automatic bit gu(int i);
        return (i < 0) ? 1'b0 : ref_u[i];
    endfunction
    function automatic bit gv(int i);
        return (i < 0) ? 1'b0 : ref_v[i];
    endfunction

    // Bit-serial reference: each serial time takes the phase constraint that
    // fixes its parity, shifted so that the parity term sits at distance 0.
    function automatic logic [5:0] ref_encode(logic [2:0] b);
        logic [5:0] w;
        for (int j = 0; j < 3; j++) begin
            int s = ref_cnt + j;
            int sh;
            int ut [3];
            int vt [3];
            bit v;
            case (s % 3)
                1: begin sh = 2; ut = '{2, 7, 13}; vt = '{2, 9, 16}; end
                0: begin sh = 1; ut = '{1, 6, 12}; vt = '{1, 8, 15}; end
                default: begin sh = 0; ut = '{0, 5, 11}; vt = '{0, 7, 14}; end
            endcase
            ref_u[s] = b[j];
            v = 1'b0;
            for (int t = 0; t < 3; t++) v ^= gu(s + sh - ut[t]);
            for (int t = 1; t < 3; t++) v ^= gv(s + sh - vt[t]);
            ref_v[s] = v;
            w[j]   = b[j];
            w[3+j] = v;
        end
        ref_cnt += 3;
        return w;
    endfunction

    task automatic check(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(logic [2:0] b, string tag);
        in_valid = 1'b1;
        in_info  = b;
        @(negedge clk);
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk);
        end
        exp_q.push_back(ref_encode(b));
        tag_q.push_back(tag);
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        check("R4 out_valid after accept", {5'd0, out_valid}, 6'd1);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic do_flush();
        @(posedge clk);
        #2;
        flush = 1'b1;
        @(posedge clk);
        #2;
        flush = 1'b0;
        ref_cnt = 0;
        exp_q.delete();
        tag_q.delete();
        @(negedge clk);
        check("R7 out_valid after flush", {5'd0, out_valid}, 6'd0);
        @(posedge clk);
        #2;
    endtask

    // consumer side
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
        endcase
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R4 unexpected word actual=%h expected=none", out_word);
                end else begin
                    logic [5:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, out_word, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] held;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", {5'd0, out_valid}, 6'd0);
        check("R1 in_ready after reset", {5'd0, in_ready}, 6'd1);
        @(posedge clk);
        #2;

        // zero stream after reset
        for (int i = 0; i < 8; i++) send(3'b000, "R1 zero stream");

        // impulse response through every tap
        do_flush();
        send(3'b001, "R2 impulse lane0");
        for (int i = 0; i < 10; i++) send(3'b000, "R2 impulse tail");
        do_flush();
        send(3'b100, "R2 impulse lane2");
        for (int i = 0; i < 10; i++) send(3'b000, "R2 impulse tail");
        for (int i = 0; i < 8; i++) send(3'b111, "R3 all ones");

        // random stream with stalls and idle gaps
        rdy_mode = 1;
        for (int i = 0; i < 300; i++) begin
            send(3'($urandom_range(0, 7)), "R8 random with gaps/stalls");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        rdy_mode = 0;
        idle(4);

        // back-to-back burst at full rate
        stall_cnt = 0;
        for (int i = 0; i < 40; i++) send(3'($urandom_range(0, 7)), "R6 burst data");
        check("R6 no stall in burst", 6'(stall_cnt), 6'd0);
        idle(3);

        // held word under backpressure, then flush it away
        rdy_mode = 2;
        idle(1);
        send(3'b101, "R5 held word");
        held = out_word;
        idle(3);
        @(negedge clk);
        check("R5 word stable under stall", out_word, held);
        check("R5 out_valid held", {5'd0, out_valid}, 6'd1);
        check("R5 in_ready low under stall", {5'd0, in_ready}, 6'd0);
        @(posedge clk);
        #2;
        do_flush();
        rdy_mode = 0;
        idle(1);
        send(3'b001, "R7 restart after flush");
        for (int i = 0; i < 10; i++) send(3'b000, "R7 restart tail");
        idle(5);
        check("R4 scoreboard drained", 6'(exp_q.size()), 6'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule